// File: doc/BRIEF.md
# Collision-Checking Serial Transmitter

This block sends bytes as asynchronous serial frames on a line that several nodes share. Each node reads the wire back on its receive pin. Software, or a neighbouring register block, writes a byte into a one-entry holding buffer. When transmission is enabled, the byte moves into a shift register and goes out on `txd`. The frame is one low start bit, eight data bits with the least significant bit first, and one high stop bit. Each bit lasts sixteen baud ticks, and the baud ticks come from an external strobe.

While a frame is on the wire, the block compares the level it reads on `rxd` with the bit it is driving. Any disagreement at a sampling instant means another node is driving the line. The block then sets a sticky collision flag. If configured to, it also drops its own transmit enable so that the frame stops at the next bit boundary. The sampling instant is selectable: either the mid-bit rising edge of the internal transfer clock, or a strobe from an outside timer.

A frame can start as soon as data and enable are present, or only after a falling edge on `rxd`. A single interrupt pulse reports either that the buffer has emptied or that the whole frame has finished.

Top module: `uart_cd_tx`

## Requirements
- R1: While no frame is active, `txd` is 1. A frame drives 0 for the start bit, then data bits 0 through 7, then 1 for the stop bit. Each bit lasts 16 `baud_tick` pulses.
- R2: With `cfg_start_sel`=0, a frame starts in the clock cycle after the buffer holds data while `tx_en` is 1. The byte then leaves the buffer, so `buf_empty` reads 1 and the next byte may be written during the current frame. That next byte follows directly as the next frame.
- R3: `tx_done` is 1 exactly when no frame is active and the buffer is empty. A byte waiting in the buffer keeps it at 0 across a frame boundary.
- R4: With `cfg_start_sel`=1, buffered data waits while `rxd` stays high. The frame starts when `rxd` is seen at 1 on one clock and at 0 on the next.
- R5: With `cfg_smp_sel`=0, the line is sampled once per bit, on the eighth tick of that bit. If the sampled `rxd` differs from `txd` while a frame is active, `col_flag` is set and stays set. A frame read back unchanged never sets it.
- R6: With `cfg_smp_sel`=1, the line is sampled only on cycles where `tmr_uf` is 1. Mismatches at other times, including mid-bit, set nothing.
- R7: A cycle with `col_clr`=1 and no new collision clears `col_flag`.
- R8: When `cfg_auto_clr`=1, a detected collision clears `tx_en` on the next clock. When `cfg_auto_clr`=0, `tx_en` stays 1. `te_set` sets `tx_en` and `te_clr` clears it.
- R9: If `tx_en` is 0 at the end of a bit, the frame stops: `txd` returns to 1 at that bit boundary, and the buffered byte is discarded, so `buf_empty` and `tx_done` read 1.
- R10: With `cfg_irq_sel`=0, `irq` pulses for exactly one cycle each time `buf_empty` rises.
- R11: With `cfg_irq_sel`=1, `irq` pulses for exactly one cycle each time `tx_done` rises, which happens after the stop bit, and not before.
- R12: After reset, `txd`=1, `buf_empty`=1, `tx_done`=1, `tx_en`=0, `col_flag`=0 and `irq`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| baud_tick | input | 1 | One-cycle strobe, sixteen per bit |
| tmr_uf | input | 1 | External timer underflow strobe used as the sampling point |
| rxd | input | 1 | Line level read back |
| wr_en | input | 1 | Write strobe for the holding buffer |
| wr_data | input | 8 | Byte to send |
| te_set | input | 1 | Set transmit enable |
| te_clr | input | 1 | Clear transmit enable |
| col_clr | input | 1 | Clear the collision flag (write one to clear) |
| cfg_smp_sel | input | 1 | 0: sample at mid-bit, 1: sample on `tmr_uf` |
| cfg_auto_clr | input | 1 | 1: a collision clears transmit enable |
| cfg_start_sel | input | 1 | 1: a frame also waits for a falling edge on `rxd` |
| cfg_irq_sel | input | 1 | 0: interrupt on buffer empty, 1: on frame complete |
| txd | output | 1 | Serial output |
| tx_en | output | 1 | Transmit enable state |
| col_flag | output | 1 | Sticky collision flag |
| buf_empty | output | 1 | Holding buffer is free |
| tx_done | output | 1 | Shifter idle and buffer empty |
| irq | output | 1 | One-cycle interrupt pulse |

## Verification
The hardest state to reach from the ports is an abort that must throw away a second, already-buffered byte. That needs a collision with auto-clear active, and the buffer must be refilled before the first bit boundary of the frame that is being aborted. The bench gets there in a set sequence. It holds `rxd` high with loopback off, so the start bit mismatches at its mid-point. It writes the second byte as soon as `buf_empty` shows that the first byte has moved into the shifter. It then counts baud ticks past the boundary and checks the idle line and both empty flags. Random bytes sent with loopback on, and with the interrupt cause changed at random, surround these directed cases.

// File: rtl/uart_cd_pkg.sv
package uart_cd_pkg;
    typedef enum logic {
        TX_IDLE  = 1'b0,
        TX_SHIFT = 1'b1
    } tx_state_e;
endpackage

// File: rtl/uart_cd_bittimer.sv
module uart_cd_bittimer #(
    parameter int unsigned TICKS_PER_BIT = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic baud_tick,
    output logic mid_stb,
    output logic end_stb
);
    localparam int unsigned CNT_W = (TICKS_PER_BIT > 1) ? $clog2(TICKS_PER_BIT) : 1;
    localparam logic [CNT_W-1:0] MID_CNT  = CNT_W'(TICKS_PER_BIT / 2 - 1);
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(TICKS_PER_BIT - 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    // Counts ticks within the current bit; held at zero while no frame runs.
    always_comb begin
        cnt_d = cnt_q;
        if (!run) begin
            cnt_d = '0;
        end else if (baud_tick) begin
            cnt_d = (cnt_q == LAST_CNT) ? '0 : cnt_q + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign mid_stb = run & baud_tick & (cnt_q == MID_CNT);
    assign end_stb = run & baud_tick & (cnt_q == LAST_CNT);
endmodule

// File: rtl/uart_cd_colchk.sv
module uart_cd_colchk (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic smp_sel,
    input  logic mid_stb,
    input  logic tmr_uf,
    input  logic rxd,
    input  logic txd,
    input  logic clr,
    output logic col_evt,
    output logic col_flag
);
    logic flag_d, flag_q;
    logic smp_stb;

    always_comb begin
        smp_stb = smp_sel ? tmr_uf : mid_stb;
        col_evt = run & smp_stb & (rxd != txd);
        flag_d  = flag_q;
        if (clr)     flag_d = 1'b0;
        if (col_evt) flag_d = 1'b1;   // a fresh collision beats the clear
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flag_q <= 1'b0;
        else        flag_q <= flag_d;
    end

    assign col_flag = flag_q;
endmodule

// File: rtl/uart_cd_irqgen.sv
module uart_cd_irqgen (
    input  logic clk,
    input  logic rst_n,
    input  logic sel,
    input  logic buf_empty,
    input  logic tx_done,
    output logic irq
);
    typedef struct packed {
        logic prev;
        logic pulse;
    } irq_t;

    irq_t s_d, s_q;
    logic cause;

    always_comb begin
        cause     = sel ? tx_done : buf_empty;
        s_d.prev  = cause;
        s_d.pulse = cause & ~s_q.prev;
    end

    // Both causes are high out of reset, so prev starts at 1.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{prev: 1'b1, pulse: 1'b0};
        else        s_q <= s_d;
    end

    assign irq = s_q.pulse;
endmodule

// File: rtl/uart_cd_tx.sv
module uart_cd_tx
    import uart_cd_pkg::*;
#(
    parameter int unsigned DATA_W        = 8,
    parameter int unsigned TICKS_PER_BIT = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              baud_tick,
    input  logic              tmr_uf,
    input  logic              rxd,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              te_set,
    input  logic              te_clr,
    input  logic              col_clr,
    input  logic              cfg_smp_sel,
    input  logic              cfg_auto_clr,
    input  logic              cfg_start_sel,
    input  logic              cfg_irq_sel,
    output logic              txd,
    output logic              tx_en,
    output logic              col_flag,
    output logic              buf_empty,
    output logic              tx_done,
    output logic              irq
);
    localparam int unsigned FRAME_W = DATA_W + 2;
    localparam int unsigned IDX_W   = $clog2(FRAME_W);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_W - 1);

    typedef struct packed {
        tx_state_e          st;
        logic [FRAME_W-1:0] shr;
        logic [IDX_W-1:0]   idx;
        logic [DATA_W-1:0]  hold;
        logic               full;
        logic               te;
        logic               rxd_prev;
    } core_t;

    core_t c_d, c_q;
    logic  busy_q;
    logic  mid_stb, end_stb;
    logic  col_evt;
    logic  rxd_fall;
    logic  start_ok;

    assign busy_q = (c_q.st == TX_SHIFT);

    uart_cd_bittimer #(.TICKS_PER_BIT(TICKS_PER_BIT)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (busy_q),
        .baud_tick (baud_tick),
        .mid_stb   (mid_stb),
        .end_stb   (end_stb)
    );

    uart_cd_colchk u_col (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (busy_q),
        .smp_sel  (cfg_smp_sel),
        .mid_stb  (mid_stb),
        .tmr_uf   (tmr_uf),
        .rxd      (rxd),
        .txd      (txd),
        .clr      (col_clr),
        .col_evt  (col_evt),
        .col_flag (col_flag)
    );

    always_comb begin
        c_d          = c_q;
        c_d.rxd_prev = rxd;
        rxd_fall     = c_q.rxd_prev & ~rxd;
        start_ok     = c_q.te & c_q.full & (~cfg_start_sel | rxd_fall);

        // Transmit enable: a hardware clear on collision wins over everything.
        if (te_set) c_d.te = 1'b1;
        if (te_clr) c_d.te = 1'b0;
        if (col_evt && cfg_auto_clr) c_d.te = 1'b0;

        if (busy_q) begin
            if (end_stb) begin
                if (!c_q.te) begin
                    // Stop at the bit boundary and drop any pending byte.
                    c_d.st   = TX_IDLE;
                    c_d.shr  = '1;
                    c_d.full = 1'b0;
                end else if (c_q.idx == LAST_IDX) begin
                    c_d.st  = TX_IDLE;
                    c_d.shr = '1;
                end else begin
                    c_d.shr = {1'b1, c_q.shr[FRAME_W-1:1]};
                    c_d.idx = c_q.idx + IDX_W'(1);
                end
            end
        end else if (start_ok) begin
            c_d.st   = TX_SHIFT;
            c_d.shr  = {1'b1, c_q.hold, 1'b0};
            c_d.idx  = '0;
            c_d.full = 1'b0;
        end

        // A write in the same cycle is kept after a move or a discard.
        if (wr_en) begin
            c_d.hold = wr_data;
            c_d.full = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q <= '{st: TX_IDLE, shr: '1, idx: '0, hold: '0,
                     full: 1'b0, te: 1'b0, rxd_prev: 1'b0};
        end else begin
            c_q <= c_d;
        end
    end

    assign txd       = busy_q ? c_q.shr[0] : 1'b1;
    assign tx_en     = c_q.te;
    assign buf_empty = ~c_q.full;
    assign tx_done   = ~busy_q & ~c_q.full;

    uart_cd_irqgen u_irq (
        .clk       (clk),
        .rst_n     (rst_n),
        .sel       (cfg_irq_sel),
        .buf_empty (buf_empty),
        .tx_done   (tx_done),
        .irq       (irq)
    );
endmodule

// File: rtl/uart_cd_tx_chk.sv
module uart_cd_tx_chk (
    input logic clk,
    input logic rst_n,
    input logic busy,
    input logic col_evt,
    input logic tmr_uf,
    input logic rxd,
    input logic te_clr,
    input logic col_clr,
    input logic cfg_smp_sel,
    input logic cfg_auto_clr,
    input logic cfg_start_sel,
    input logic txd,
    input logic tx_en,
    input logic col_flag,
    input logic buf_empty,
    input logic tx_done,
    input logic irq
);
    a_r1_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> txd);

    a_r3_done_implies_empty: assert property (@(posedge clk) disable iff (!rst_n)
        tx_done |-> (buf_empty && txd));

    a_r4_gate_waits: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && cfg_start_sel && rxd) |=> !busy);

    a_r6_timer_only: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_smp_sel && !tmr_uf) |-> !col_evt);

    a_r7_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (col_flag && !col_clr) |=> col_flag);

    a_r8_auto_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (col_evt && cfg_auto_clr) |=> !tx_en);

    a_r8_enable_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_en && !te_clr && !(col_evt && cfg_auto_clr)) |=> tx_en);

    a_r10_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);
endmodule

bind uart_cd_tx uart_cd_tx_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .busy          (busy_q),
    .col_evt       (col_evt),
    .tmr_uf        (tmr_uf),
    .rxd           (rxd),
    .te_clr        (te_clr),
    .col_clr       (col_clr),
    .cfg_smp_sel   (cfg_smp_sel),
    .cfg_auto_clr  (cfg_auto_clr),
    .cfg_start_sel (cfg_start_sel),
    .txd           (txd),
    .tx_en         (tx_en),
    .col_flag      (col_flag),
    .buf_empty     (buf_empty),
    .tx_done       (tx_done),
    .irq           (irq)
);

// File: tb/uart_cd_tx_test.sv
module uart_cd_tx_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic baud_tick = 1'b0;
    logic tmr_uf = 1'b0;
    logic rxd_drv = 1'b1;
    logic loop_en = 1'b1;
    logic rxd;
    logic wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic te_set = 1'b0, te_clr = 1'b0, col_clr = 1'b0;
    logic cfg_smp_sel = 1'b0, cfg_auto_clr = 1'b0, cfg_start_sel = 1'b0, cfg_irq_sel = 1'b0;
    logic txd, tx_en, col_flag, buf_empty, tx_done, irq;

    int n_chk = 0;
    int n_bad = 0;
    int irq_cnt = 0;
    int tcount = 0;
    int bdiv = 0;

    always #4 clk = ~clk;

    assign rxd = loop_en ? txd : rxd_drv;

    uart_cd_tx uut (
        .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .tmr_uf(tmr_uf),
        .rxd(rxd), .wr_en(wr_en), .wr_data(wr_data), .te_set(te_set),
        .te_clr(te_clr), .col_clr(col_clr), .cfg_smp_sel(cfg_smp_sel),
        .cfg_auto_clr(cfg_auto_clr), .cfg_start_sel(cfg_start_sel),
        .cfg_irq_sel(cfg_irq_sel), .txd(txd), .tx_en(tx_en),
        .col_flag(col_flag), .buf_empty(buf_empty), .tx_done(tx_done), .irq(irq)
    );

    // Baud strobe: one cycle in four, changed only on falling edges.
    always @(negedge clk) begin
        bdiv = (bdiv + 1) % 4;
        baud_tick <= (bdiv == 0);
    end

    always @(negedge clk) if (rst_n && irq) irq_cnt++;

    function automatic logic frame_bit(input logic [7:0] d, input int i);
        if (i == 0) return 1'b0;
        if (i == 9) return 1'b1;
        return d[i-1];
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    endtask

    task automatic put(input logic [7:0] d);
        @(negedge clk); wr_en = 1'b1; wr_data = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic pulse_te(input logic set);
        @(negedge clk); if (set) te_set = 1'b1; else te_clr = 1'b1;
        @(negedge clk); te_set = 1'b0; te_clr = 1'b0;
    endtask

    task automatic pulse_colclr();
        @(negedge clk); col_clr = 1'b1;
        @(negedge clk); col_clr = 1'b0;
    endtask

    task automatic wait_start();
        int g = 0;
        do begin @(posedge clk); #1; g++; end while (txd !== 1'b0 && g < 4000);
        if (g >= 4000) check("R1 start bit seen", 32'd0, 32'd1);
        tcount = 0;
    endtask

    task automatic tick_to(input int target);
        while (tcount < target) begin
            @(posedge clk);
            if (baud_tick) tcount++;
            #1;
        end
    endtask

    task automatic wait_done();
        int g = 0;
        while (tx_done !== 1'b1 && g < 4000) begin @(negedge clk); g++; end
        if (g >= 4000) check("R3 tx_done reached", 32'd0, 32'd1);
        repeat (3) @(negedge clk);
    endtask

    task automatic rx_check(input logic [7:0] d, input string req);
        wait_start();
        for (int i = 0; i < 10; i++) begin
            tick_to(16 * i + 8);
            check(req, {31'd0, txd}, {31'd0, frame_bit(d, i)});
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        int base;
        logic [7:0] b;
        void'($urandom(32'h1c0d_5eed));
        repeat (3) @(negedge clk);
        // R12 reset state
        check("R12 txd", {31'd0, txd}, 32'd1);
        check("R12 buf_empty", {31'd0, buf_empty}, 32'd1);
        check("R12 tx_done", {31'd0, tx_done}, 32'd1);
        check("R12 tx_en", {31'd0, tx_en}, 32'd0);
        check("R12 col_flag", {31'd0, col_flag}, 32'd0);
        check("R12 irq", {31'd0, irq}, 32'd0);
        @(negedge clk); rst_n = 1'b1;
        repeat (4) @(negedge clk);

        // R8 enable set; R2/R3 buffer handoff; R1 frame; R10 irq on empty
        pulse_te(1'b1);
        check("R8 te_set", {31'd0, tx_en}, 32'd1);
        base = irq_cnt;
        put(8'hA5);
        check("R2 buffer holds byte", {31'd0, buf_empty}, 32'd0);
        @(negedge clk);
        check("R2 buffer freed at start", {31'd0, buf_empty}, 32'd1);
        check("R3 busy not done", {31'd0, tx_done}, 32'd0);
        rx_check(8'hA5, "R1 frame A5");
        wait_done();
        check("R10 one irq on empty", irq_cnt - base, 32'd1);

        // R11 irq at frame completion only
        cfg_irq_sel = 1'b1;
        base = irq_cnt;
        put(8'h3C);
        rx_check(8'h3C, "R1 frame 3C");
        check("R11 no irq before stop ends", irq_cnt - base, 32'd0);
        wait_done();
        check("R11 one irq after frame", irq_cnt - base, 32'd1);

        // R2/R3 back-to-back
        put(8'h81);
        while (buf_empty !== 1'b1) @(negedge clk);
        put(8'h7E);
        rx_check(8'h81, "R2 first of pair");
        check("R3 pending byte keeps done low", {31'd0, tx_done}, 32'd0);
        rx_check(8'h7E, "R2 second of pair");
        wait_done();

        // R5 random loopback frames, no false collisions; R10/R11 irq per frame
        for (int k = 0; k < 16; k++) begin
            b = 8'($urandom);
            cfg_irq_sel = 1'($urandom);
            base = irq_cnt;
            put(b);
            rx_check(b, "R1 random frame");
            wait_done();
            check(cfg_irq_sel ? "R11 irq per frame" : "R10 irq per frame", irq_cnt - base, 32'd1);
        end
        check("R5 no collision on clean readback", {31'd0, col_flag}, 32'd0);

        // R4 start gated on rxd falling edge
        cfg_start_sel = 1'b1;
        @(negedge clk); loop_en = 1'b0; rxd_drv = 1'b1;
        put(8'h5A);
        repeat (60) @(negedge clk);
        check("R4 waits for edge txd", {31'd0, txd}, 32'd1);
        check("R4 waits for edge buffer", {31'd0, buf_empty}, 32'd0);
        @(negedge clk); rxd_drv = 1'b0;
        @(negedge clk); loop_en = 1'b1;
        rx_check(8'h5A, "R4 frame after edge");
        wait_done();
        check("R4 no collision", {31'd0, col_flag}, 32'd0);
        cfg_start_sel = 1'b0;

        // R5/R8 collision at mid-bit without auto clear
        @(negedge clk); loop_en = 1'b0; rxd_drv = 1'b1;
        put(8'h00);
        wait_start();
        tick_to(6);
        check("R5 not before mid-bit", {31'd0, col_flag}, 32'd0);
        tick_to(10);
        check("R5 collision flagged", {31'd0, col_flag}, 32'd1);
        check("R8 enable kept", {31'd0, tx_en}, 32'd1);
        wait_done();
        check("R5 flag sticky", {31'd0, col_flag}, 32'd1);
        pulse_colclr();
        check("R7 flag cleared", {31'd0, col_flag}, 32'd0);

        // R6 timer-strobe sampling
        cfg_smp_sel = 1'b1;
        put(8'h00);
        wait_done();
        check("R6 mid-bit ignored", {31'd0, col_flag}, 32'd0);
        put(8'h00);
        wait_start();
        tick_to(4);
        @(negedge clk); tmr_uf = 1'b1;
        @(negedge clk); tmr_uf = 1'b0;
        check("R6 strobe samples", {31'd0, col_flag}, 32'd1);
        wait_done();
        pulse_colclr();
        cfg_smp_sel = 1'b0;

        // R8/R9 auto clear aborts frame and discards pending byte
        cfg_auto_clr = 1'b1;
        put(8'h00);
        while (buf_empty !== 1'b1) @(negedge clk);
        put(8'h55);
        wait_start();
        tick_to(10);
        check("R8 auto clear", {31'd0, tx_en}, 32'd0);
        check("R5 flag on abort frame", {31'd0, col_flag}, 32'd1);
        tick_to(13);
        check("R9 bit still driven", {31'd0, txd}, 32'd0);
        tick_to(18);
        check("R9 line idle after boundary", {31'd0, txd}, 32'd1);
        check("R9 buffer discarded", {31'd0, buf_empty}, 32'd1);
        check("R9 done after abort", {31'd0, tx_done}, 32'd1);
        repeat (100) @(negedge clk);
        check("R9 no later frame", {31'd0, txd}, 32'd1);
        cfg_auto_clr = 1'b0;
        pulse_colclr();
        @(negedge clk); loop_en = 1'b1;

        // R9/R8 software clear mid-frame
        pulse_te(1'b1);
        put(8'h00);
        wait_start();
        tick_to(40);
        pulse_te(1'b0);
        check("R8 te_clr", {31'd0, tx_en}, 32'd0);
        tick_to(44);
        check("R9 bit held to boundary", {31'd0, txd}, 32'd0);
        tick_to(51);
        check("R9 idle after clear", {31'd0, txd}, 32'd1);
        check("R9 done after clear", {31'd0, tx_done}, 32'd1);
        check("R7 flag stays clear", {31'd0, col_flag}, 32'd0);

        summary();
        $finish;
    end
endmodule